// File: doc/BRIEF.md
# System Handler State Register

This block holds the active and pended flags of six fixed system exception handlers: memory-management fault, bus fault, usage fault, supervisor call, debug monitor and the deferred service request. The exception-sequencing logic reports handler entry, handler return, late-arrival displacement, handler start, stacking error and vector-fetch error. It sends one event per cycle, and each event carries a three-bit handler identifier. The block turns these events into set and clear actions on individual flag bits.

A 32-bit register port lets software read the flags and write them directly. A context switcher can use this to move the active state of stacked handlers in and out. A software write changes only the flag bits. The current exception number and any stacked state lie outside this block and are never touched. Read data is registered, so it shows the flag contents of the previous cycle.

Top module: `sys_handler_state_reg`

Handler identifiers (`evt_id`): 0 memory-management fault, 1 bus fault, 2 usage fault, 3 supervisor call, 4 debug monitor, 5 deferred service request; 6 and 7 are unused. Event codes (`evt_kind`): 0 none, 1 entry, 2 return, 3 displacement, 4 start, 5 stacking error, 6 vector-fetch error.

## Requirements
- R1: A synchronous active-high reset clears every flag. The flags read as 0 after reset.
- R2: An entry event sets the active flag of its handler on that clock edge. The active flags sit at these word bits: id 0 at bit 0, id 1 at bit 1, id 2 at bit 3, id 3 at bit 7, id 4 at bit 8, id 5 at bit 10.
- R3: A return event clears the active flag of its handler and leaves every other flag unchanged.
- R4: A displacement event on id 3 sets the supervisor-call pended flag at bit 15. A displacement event on id 1 sets the bus-fault pended flag at bit 14. A displacement event on any other id changes no flag.
- R5: Stacking-error and vector-fetch-error events leave every flag unchanged, pended flags included.
- R6: A start event clears the pended flag of its handler (bit 15 for id 3, bit 14 for id 1) and leaves its active flag unchanged.
- R7: When `reg_wr` is high, the six active flags and the two pended flags take the values on the matching bits of `reg_wdata`. Setting and clearing are both possible.
- R8: Bits 2, 4, 5, 6, 9, 11 to 13 and 16 to 31 always read as 0, and writing 1 to them has no effect.
- R9: If an event and a software write target the same bit in one cycle, the bit takes the value the event gives. The other bits take the write data.
- R10: `reg_rdata` shows the flag contents as they were one cycle earlier. A change made at one clock edge appears on `reg_rdata` after the next edge.
- R11: Events that carry identifier 6 or 7 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_kind | input | 3 | Event code from exception sequencing, 0 for no event |
| evt_id | input | 3 | Handler identifier of the event |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench drives a displacement and then stacking-error and vector-fetch-error events, and checks that both pended flags survive. A design that cleared pending on any error would lose the retry information. The bench also issues a start event on a handler that is both active and pended, which catches a design that clears the wrong flag. Same-cycle write and event conflicts are tested in both directions: a write of 0 against an entry and a write of all ones against a return, to expose a design that lets software win. Other tests write all ones into reserved bits, send events with unused identifiers, and sample read data one cycle after a write, to show leaking reserved storage, aliased identifiers and a read path without its register stage.

// File: rtl/shs_pkg.sv
package shs_pkg;

    localparam int WORD_W = 32;
    localparam int HID_W  = 3;
    localparam int KIND_W = 3;

    typedef enum logic [HID_W-1:0] {
        HID_MEMMGT = 3'd0,
        HID_BUSERR = 3'd1,
        HID_USAGE  = 3'd2,
        HID_SVCALL = 3'd3,
        HID_DBGMON = 3'd4,
        HID_DEFER  = 3'd5
    } hid_e;

    typedef enum logic [KIND_W-1:0] {
        EV_NONE     = 3'd0,
        EV_ENTER    = 3'd1,
        EV_RETURN   = 3'd2,
        EV_DISPLACE = 3'd3,
        EV_START    = 3'd4,
        EV_STKERR   = 3'd5,
        EV_VECERR   = 3'd6
    } evt_kind_e;

    typedef struct packed {
        evt_kind_e             kind;
        logic [HID_W-1:0]      id;
    } hw_evt_t;

    typedef struct packed {
        logic [WORD_W-1:0] set;
        logic [WORD_W-1:0] clr;
    } bit_cmd_t;

    localparam logic [WORD_W-1:0] ACT_MASK  = 32'h0000_058B;
    localparam logic [WORD_W-1:0] PEND_MASK = 32'h0000_C000;
    localparam logic [WORD_W-1:0] IMPL_MASK = ACT_MASK | PEND_MASK;

    function automatic logic [WORD_W-1:0] act_mask_of(input logic [HID_W-1:0] id);
        logic [WORD_W-1:0] m;
        m = '0;
        case (id)
            HID_MEMMGT: m[0]  = 1'b1;
            HID_BUSERR: m[1]  = 1'b1;
            HID_USAGE:  m[3]  = 1'b1;
            HID_SVCALL: m[7]  = 1'b1;
            HID_DBGMON: m[8]  = 1'b1;
            HID_DEFER:  m[10] = 1'b1;
            default:    m     = '0;
        endcase
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pend_mask_of(input logic [HID_W-1:0] id);
        logic [WORD_W-1:0] m;
        m = '0;
        case (id)
            HID_BUSERR: m[14] = 1'b1;
            HID_SVCALL: m[15] = 1'b1;
            default:    m     = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/shs_evt_decode.sv
module shs_evt_decode
    import shs_pkg::*;
(
    input  hw_evt_t  evt,
    output bit_cmd_t cmd
);
    always_comb begin
        cmd = '0;
        case (evt.kind)
            EV_ENTER:    cmd.set = act_mask_of(evt.id);
            EV_RETURN:   cmd.clr = act_mask_of(evt.id);
            EV_DISPLACE: cmd.set = pend_mask_of(evt.id);
            EV_START:    cmd.clr = pend_mask_of(evt.id);
            // stacking and vector errors deliberately leave pending intact
            default:     cmd     = '0;
        endcase
    end

    // R9
    always_comb begin
        exclusive_cmd_chk: assert ((cmd.set & cmd.clr) == '0);
    end

endmodule

// File: rtl/shs_flag_store.sv
module shs_flag_store
    import shs_pkg::*;
#(
    parameter int                W    = WORD_W,
    parameter logic [W-1:0]      IMPL = IMPL_MASK
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_data,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)            q <= 1'b0;
                else if (hw_set[i]) q <= 1'b1;
                else if (hw_clr[i]) q <= 1'b0;
                else if (sw_wr)     q <= sw_data[i];
            end
            assign flags[i] = q;

            // R9
            hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                hw_set[i] |=> flags[i]);
            // R3
            hw_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
                (hw_clr[i] && !hw_set[i]) |=> !flags[i]);
        end else begin : g_rsvd
            assign flags[i] = 1'b0;
        end
    end

endmodule

// File: rtl/shs_readback.sv
module shs_readback
    import shs_pkg::*;
#(
    parameter int W = WORD_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flags,
    output logic [W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= flags;
    end

    // R10
    rdata_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rdata == $past(flags)));

endmodule

// File: rtl/sys_handler_state_reg.sv
module sys_handler_state_reg
    import shs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  evt_kind,
    input  logic [2:0]  evt_id,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    hw_evt_t           evt;
    bit_cmd_t          cmd;
    logic [WORD_W-1:0] flags;

    assign evt.kind = evt_kind_e'(evt_kind);
    assign evt.id   = evt_id;

    shs_evt_decode u_dec (
        .evt (evt),
        .cmd (cmd)
    );

    shs_flag_store #(.W(WORD_W), .IMPL(IMPL_MASK)) u_store (
        .clk     (clk),
        .rst     (rst),
        .hw_set  (cmd.set),
        .hw_clr  (cmd.clr),
        .sw_wr   (reg_wr),
        .sw_data (reg_wdata),
        .flags   (flags)
    );

    shs_readback #(.W(WORD_W)) u_rb (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .rdata (reg_rdata)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags == '0));
    // R4
    svc_displace_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_kind == EV_DISPLACE && evt_id == HID_SVCALL) |=> flags[15]);
    // R5
    err_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt_kind == EV_STKERR || evt_kind == EV_VECERR) && !reg_wr) |=> $stable(flags));
    // R11
    bad_id_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_id > 3'd5 && !reg_wr) |=> $stable(flags));
    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~IMPL_MASK) == '0);

endmodule

// File: tb/sim_sys_handler_state_reg.sv
module sim_sys_handler_state_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  evt_kind;
    logic [2:0]  evt_id;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_w;
    bit done = 0;

    always #10 clk = ~clk;

    sys_handler_state_reg u0 (
        .clk(clk), .rst(rst), .evt_kind(evt_kind), .evt_id(evt_id),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] act_bit(input int id);
        case (id)
            0: return 32'h1;
            1: return 32'h2;
            2: return 32'h8;
            3: return 32'h80;
            4: return 32'h100;
            5: return 32'h400;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_evt(input int kind, input int id);
        @(negedge clk);
        evt_kind = kind[2:0];
        evt_id   = id[2:0];
        @(negedge clk);
        evt_kind = 3'd0;
        evt_id   = 3'd0;
    endtask

    task automatic do_wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic peek(output logic [31:0] v);
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        exp_w = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        apply_reset();
        peek(v);
        check("R1 reset clears", v, 32'h0);
    endtask

    task automatic t_entry_return();
        logic [31:0] v;
        for (int id = 0; id < 6; id++) begin
            do_evt(1, id);
            exp_w |= act_bit(id);
            peek(v);
            check("R2 entry sets active bit", v, exp_w);
        end
        for (int id = 5; id >= 0; id -= 2) begin
            do_evt(2, id);
            exp_w &= ~act_bit(id);
            peek(v);
            check("R3 return clears active bit", v, exp_w);
        end
    endtask

    task automatic t_displace_errors_start();
        logic [31:0] v;
        do_evt(3, 3); exp_w |= 32'h8000;
        peek(v); check("R4 displace svc sets bit15", v, exp_w);
        do_evt(3, 1); exp_w |= 32'h4000;
        peek(v); check("R4 displace bus sets bit14", v, exp_w);
        do_evt(3, 2);
        peek(v); check("R4 displace other id no change", v, exp_w);
        do_evt(5, 3); do_evt(6, 1); do_evt(5, 1); do_evt(6, 3);
        peek(v); check("R5 errors keep pended", v, exp_w);
        do_evt(1, 3); exp_w |= 32'h80;
        do_evt(4, 3); exp_w &= ~32'h8000;
        peek(v); check("R6 start svc clears pend keeps active", v, exp_w);
        do_evt(4, 1); exp_w &= ~32'h4000;
        peek(v); check("R6 start bus clears bit14", v, exp_w);
    endtask

    task automatic t_write_lag();
        logic [31:0] v;
        logic [31:0] old;
        do_wr(32'hFFFF_FFFF); exp_w = 32'h0000_C58B;
        peek(v); check("R8 reserved read 0 after write ones", v, exp_w);
        do_wr(32'h0000_0000); exp_w = '0;
        peek(v); check("R7 write clears flags", v, exp_w);
        old = exp_w;
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h0000_8102;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
        check("R10 rdata still old one cycle after write", reg_rdata, old);
        exp_w = 32'h0000_8102;
        peek(v); check("R10 rdata new after second edge", v, exp_w);
        check("R7 write sets flags", v, 32'h0000_8102);
    endtask

    task automatic t_conflict();
        logic [31:0] v;
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h0; evt_kind = 3'd1; evt_id = 3'd4;
        @(negedge clk);
        reg_wr = 1'b0; evt_kind = 3'd0; evt_id = 3'd0;
        exp_w = 32'h0000_0100;
        peek(v); check("R9 entry beats write of zero", v, exp_w);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF; evt_kind = 3'd2; evt_id = 3'd2;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; evt_kind = 3'd0; evt_id = 3'd0;
        exp_w = 32'h0000_C583;
        peek(v); check("R9 return beats write of ones", v, exp_w);
    endtask

    task automatic t_bad_id();
        logic [31:0] v;
        do_wr(32'h0); exp_w = '0;
        do_evt(1, 6); do_evt(3, 7); do_evt(1, 7);
        peek(v); check("R11 unused ids ignored", v, exp_w);
        do_wr(32'h0000_C58B); exp_w = 32'h0000_C58B;
        do_evt(2, 6); do_evt(4, 7);
        peek(v); check("R11 unused ids do not clear", v, exp_w);
    endtask

    task automatic t_reset_again();
        logic [31:0] v;
        apply_reset();
        peek(v);
        check("R1 mid-run reset clears", v, 32'h0);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; evt_kind = '0; evt_id = '0; reg_wr = 1'b0; reg_wdata = '0;
        exp_w = '0;
        t_reset();
        t_entry_return();
        t_displace_errors_start();
        t_write_lag();
        t_conflict();
        t_bad_id();
        t_reset_again();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule